// File: doc/BRIEF.md
# Storage Test Pattern Generator and Checker

This block produces a deterministic 128-bit data stream for a write transfer to a storage device. It also regenerates that stream during a read transfer and compares it against the data that comes back. A transfer is described by a pattern code, a start position and a length. The position and the length are both counted in 512-byte sectors. A one-cycle start strobe launches the transfer. The pattern code and the direction are captured at that strobe.

In write mode the block offers words on an outgoing valid/ready stream. In read mode it accepts words on an incoming valid/ready stream and compares each one with the word it expects. Status outputs show:

- how many bytes have moved so far;
- whether any comparison has failed;
- for the first failing word only: its byte address, the word that was expected and the word that arrived.

Top module: `tpg_engine`

## Requirements
- R1: `cfg_pattern` selects the data: 0 increment, 1 decrement, 2 all zeros, 3 all ones, 4 LFSR; codes 5, 6 and 7 give all zeros. The pattern and `cfg_read` are captured on `start`.
- R2: Increment pattern: the word at byte address A has, in lane i (bits 32i+31 down to 32i, i = 0..3), the low 32 bits of A plus 4i. The first word's address is the start sector times 512, and each following word is 16 bytes higher.
- R3: Decrement pattern: every word is the bitwise inverse of the increment word at the same address.
- R4: LFSR pattern: a 32-bit register shifts left each step and takes in, at bit 0, the XOR of bits 31, 21, 1 and 0. It is seeded with the low 32 bits of the start sector, or with 1 when those bits are zero. Lane 0 of a word is the current state. Lane i is the state after i steps. The next word starts 4 steps further on.
- R5: On the first mismatch of a read transfer, `fail_addr`, `fail_exp` and `fail_got` capture the word's byte address, the expected word and the received word. Later mismatches leave them unchanged.
- R6: `byte_count` (57 bits) rises by 16 on every accepted beat and is otherwise unchanged.
- R7: `verify_fail` is set by any read mismatch and stays set until the next `start`.
- R8: A transfer of L sectors takes exactly 32·L beats. `done` pulses for one cycle, and `busy` falls, in the cycle after the last beat. With L = 0 this happens in the cycle after `start`, and no beat is accepted.
- R9: `start` clears `byte_count`, `verify_fail` and all three snapshot outputs to zero.
- R10: The streams advance only when valid and ready are both high. While busy, write mode holds `wr_valid` high and `rd_ready` low, and read mode holds `rd_ready` high and `wr_valid` low. While idle, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that launches a transfer |
| cfg_read | input | 1 | 1 = read and check, 0 = generate for write |
| cfg_pattern | input | 3 | Pattern code |
| cfg_start_sector | input | 48 | Start position in 512-byte sectors |
| cfg_len_sectors | input | 48 | Transfer length in 512-byte sectors |
| wr_valid | output | 1 | Outgoing word is valid |
| wr_ready | input | 1 | Sink accepts the outgoing word |
| wr_data | output | 128 | Outgoing pattern word |
| rd_valid | input | 1 | Incoming word is valid |
| rd_ready | output | 1 | Block accepts the incoming word |
| rd_data | input | 128 | Incoming word to check |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| byte_count | output | 57 | Bytes moved since the last start |
| verify_fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | 57 | Byte address of the first failing word |
| fail_exp | output | 128 | Expected word at the first failure |
| fail_got | output | 128 | Received word at the first failure |

## Verification
The properties assume that reset is high from time zero. They also assume that the configuration inputs matter only in the cycle of `start`, and that incoming data matters only on a beat where valid and ready are both high. The bench holds the configuration steady around each strobe and changes `rd_valid`, `wr_ready` and `rd_data` only between clock edges. It inserts random stalls, so these assumptions hold while the handshake is still stressed on every beat. It corrupts chosen beats with a nonzero mask, so that a first and a later mismatch are both present in the same transfer.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SECT_W         = 48;
    localparam int LANE_W         = 32;
    localparam int N_LANES        = 4;
    localparam int DATA_W         = LANE_W * N_LANES;
    localparam int BEAT_BYTES     = DATA_W / 8;
    localparam int SECT_BYTES     = 512;
    localparam int SECT_SHIFT     = $clog2(SECT_BYTES);
    localparam int BEATS_PER_SECT = SECT_BYTES / BEAT_BYTES;
    localparam int BPS_SHIFT      = $clog2(BEATS_PER_SECT);
    localparam int BYTE_W         = SECT_W + SECT_SHIFT;
    localparam int BEAT_W         = SECT_W + BPS_SHIFT;

    typedef enum logic [2:0] {
        PAT_INC  = 3'd0,
        PAT_DEC  = 3'd1,
        PAT_ZERO = 3'd2,
        PAT_ONES = 3'd3,
        PAT_LFSR = 3'd4
    } pat_e;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic [LANE_W-1:0] lfsr;
    } cursor_t;

    function automatic logic [LANE_W-1:0] lfsr_step(logic [LANE_W-1:0] s);
        return {s[LANE_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [LANE_W-1:0] lfsr_adv(logic [LANE_W-1:0] s, int n);
        logic [LANE_W-1:0] v;
        v = s;
        for (int k = 0; k < n; k++) v = lfsr_step(v);
        return v;
    endfunction

    function automatic logic [LANE_W-1:0] lfsr_seed(logic [SECT_W-1:0] sector);
        logic [LANE_W-1:0] v;
        v = sector[LANE_W-1:0];
        return (v == '0) ? LANE_W'(1) : v;
    endfunction
endpackage

// File: rtl/tpg_pattern.sv
module tpg_pattern
    import tpg_pkg::*;
(
    input  logic [2:0]        pat,
    input  cursor_t           cur,
    output logic [DATA_W-1:0] word
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] inc_v;
        logic [LANE_W-1:0] lfsr_v;
        assign inc_v  = cur.addr[LANE_W-1:0] + LANE_W'(i * (LANE_W / 8));
        assign lfsr_v = lfsr_adv(cur.lfsr, i);
        always_comb begin
            case (pat)
                PAT_INC:  word[i*LANE_W +: LANE_W] = inc_v;
                PAT_DEC:  word[i*LANE_W +: LANE_W] = ~inc_v;
                PAT_ONES: word[i*LANE_W +: LANE_W] = '1;
                PAT_LFSR: word[i*LANE_W +: LANE_W] = lfsr_v;
                default:  word[i*LANE_W +: LANE_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fire,
    input  logic [SECT_W-1:0] start_sector,
    input  logic [SECT_W-1:0] len_sectors,
    output logic              busy,
    output logic              done,
    output cursor_t           cur,
    output logic [BYTE_W-1:0] byte_count
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [BEAT_W-1:0] beats_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            cur        <= '0;
            byte_count <= '0;
            beats_left <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cur.addr   <= BYTE_W'(start_sector) << SECT_SHIFT;
                cur.lfsr   <= lfsr_seed(start_sector);
                byte_count <= '0;
                beats_left <= BEAT_W'(len_sectors) << BPS_SHIFT;
                if (len_sectors == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (fire) begin
                cur.addr   <= cur.addr + BYTE_W'(BEAT_BYTES);
                cur.lfsr   <= lfsr_adv(cur.lfsr, N_LANES);
                byte_count <= byte_count + BYTE_W'(BEAT_BYTES);
                beats_left <= beats_left - BEAT_W'(1);
                if (beats_left == BEAT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
    AST_LEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (start && len_sectors == '0) |=> (done && !busy)); // R8
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start && !fire) |=> $stable(byte_count)); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!start && fire) |=> byte_count == BYTE_W'($past(byte_count) + BYTE_W'(BEAT_BYTES))); // R6
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> byte_count == '0); // R9
endmodule

// File: rtl/tpg_check.sv
module tpg_check
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fire,
    input  logic [DATA_W-1:0] got,
    input  logic [DATA_W-1:0] exp,
    input  logic [BYTE_W-1:0] addr,
    output logic              fail,
    output logic [BYTE_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    timeunit 1ns;
    timeprecision 1ps;

    logic miss;
    assign miss = fire && (got != exp);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else if (miss) begin
            fail <= 1'b1;
            if (!fail) begin
                fail_addr <= addr;
                fail_exp  <= exp;
                fail_got  <= got;
            end
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail); // R7
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_got))); // R5
    AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> (!fail && fail_addr == '0)); // R9
endmodule

// File: rtl/tpg_engine.sv
module tpg_engine
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_read,
    input  logic [2:0]        cfg_pattern,
    input  logic [SECT_W-1:0] cfg_start_sector,
    input  logic [SECT_W-1:0] cfg_len_sectors,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] byte_count,
    output logic              verify_fail,
    output logic [BYTE_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    timeunit 1ns;
    timeprecision 1ps;

    logic        mode_rd;
    logic [2:0]  pat_q;
    cursor_t     cur;
    logic [DATA_W-1:0] word;
    logic        wr_fire;
    logic        rd_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_rd <= 1'b0;
            pat_q   <= '0;
        end else if (start) begin
            mode_rd <= cfg_read;
            pat_q   <= cfg_pattern;
        end
    end

    assign wr_valid = busy && !mode_rd;
    assign rd_ready = busy && mode_rd;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;
    assign wr_data  = word;

    tpg_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .fire         (wr_fire || rd_fire),
        .start_sector (cfg_start_sector),
        .len_sectors  (cfg_len_sectors),
        .busy         (busy),
        .done         (done),
        .cur          (cur),
        .byte_count   (byte_count)
    );

    tpg_pattern u_pat (
        .pat  (pat_q),
        .cur  (cur),
        .word (word)
    );

    tpg_check u_chk (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .fire      (rd_fire),
        .got       (rd_data),
        .exp       (word),
        .addr      (cur.addr),
        .fail      (verify_fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_got  (fail_got)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!wr_valid && !rd_ready)); // R10
    AST_WRITE_NO_FAIL: assert property (@(posedge clk) disable iff (rst)
        (!start && !verify_fail && wr_fire) |=> !verify_fail); // R10
endmodule

// File: tb/tb_tpg_engine.sv
module tb_tpg_engine;
    timeunit 1ns;
    timeprecision 1ps;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cfg_read = 1'b0;
    logic [2:0]   cfg_pattern = '0;
    logic [47:0]  cfg_start_sector = '0;
    logic [47:0]  cfg_len_sectors = '0;
    logic         wr_valid;
    logic         wr_ready = 1'b0;
    logic [127:0] wr_data;
    logic         rd_valid = 1'b0;
    logic         rd_ready;
    logic [127:0] rd_data = '0;
    logic         busy;
    logic         done;
    logic [56:0]  byte_count;
    logic         verify_fail;
    logic [56:0]  fail_addr;
    logic [127:0] fail_exp;
    logic [127:0] fail_got;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tpg_engine dut (.*);

    function automatic logic [31:0] b_step(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [127:0] b_word(int pat, logic [56:0] a, logic [31:0] l);
        logic [127:0] w;
        logic [31:0]  s;
        s = l;
        for (int i = 0; i < 4; i++) begin
            case (pat)
                0: w[i*32 +: 32] = a[31:0] + 32'(4 * i);
                1: w[i*32 +: 32] = ~(a[31:0] + 32'(4 * i));
                3: w[i*32 +: 32] = '1;
                4: w[i*32 +: 32] = s;
                default: w[i*32 +: 32] = '0;
            endcase
            s = b_step(s);
        end
        return w;
    endfunction

    function automatic string pat_req(int pat);
        case (pat)
            0: return "R2";
            1: return "R3";
            4: return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_xfer(bit rd, int pat, logic [47:0] sec, logic [47:0] len,
                            int bad1, int bad2, int stall_pct);
        logic [56:0]  m_addr;
        logic [31:0]  m_lfsr;
        logic [127:0] exp_w;
        logic [127:0] mask;
        logic [56:0]  s_addr;
        logic [127:0] s_exp;
        logic [127:0] s_got;
        longint       total;
        longint       hs;
        bit           bad_seen;
        bit           ok;
        @(negedge clk);
        cfg_read = rd;
        cfg_pattern = 3'(pat);
        cfg_start_sector = sec;
        cfg_len_sectors = len;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_addr = {sec, 9'b0};
        m_lfsr = (sec[31:0] == 0) ? 32'd1 : sec[31:0];
        total = longint'(len) * 32;
        hs = 0;
        bad_seen = 1'b0;
        s_addr = '0; s_exp = '0; s_got = '0;
        // R9: status cleared right after start
        chk(byte_count == 0 && !verify_fail && fail_addr == 0 && fail_exp == 0 && fail_got == 0,
            "R9", {71'b0, byte_count}, 128'b0);
        forever begin
            if (hs == total) begin
                chk(done && !busy, "R8", {126'b0, done, busy}, 128'b10);
                break;
            end
            ok = (byte_count == 57'(hs * 16)) && !done && busy;
            if (!ok) chk(ok, "R6", {71'b0, byte_count}, 128'(hs * 16));
            exp_w = b_word(pat, m_addr, m_lfsr);
            if (rd) begin
                ok = rd_ready && !wr_valid;
                if (!ok) chk(ok, "R10", {126'b0, rd_ready, wr_valid}, 128'b10);
                rd_valid = ($urandom_range(99) >= stall_pct);
                mask = {$urandom, $urandom, $urandom, $urandom} | 128'h1;
                rd_data = (hs == bad1 || hs == bad2) ? (exp_w ^ mask) : exp_w;
                if (rd_valid) begin
                    if ((hs == bad1 || hs == bad2) && !bad_seen) begin
                        bad_seen = 1'b1;
                        s_addr = m_addr; s_exp = exp_w; s_got = rd_data;
                    end
                end
            end else begin
                ok = wr_valid && !rd_ready;
                if (!ok) chk(ok, "R10", {126'b0, wr_valid, rd_ready}, 128'b10);
                wr_ready = ($urandom_range(99) >= stall_pct);
                if (wr_ready) chk(wr_data == exp_w, pat_req(pat), wr_data, exp_w);
            end
            if ((rd && rd_valid) || (!rd && wr_ready)) begin
                hs++;
                m_addr = m_addr + 57'd16;
                for (int k = 0; k < 4; k++) m_lfsr = b_step(m_lfsr);
            end
            @(negedge clk);
        end
        wr_ready = 1'b0;
        rd_valid = 1'b0;
        chk(byte_count == 57'(total * 16), "R6", {71'b0, byte_count}, 128'(total * 16));
        chk(verify_fail == bad_seen, "R7", {127'b0, verify_fail}, {127'b0, bad_seen});
        if (bad_seen) begin
            chk(fail_addr == s_addr, "R5", {71'b0, fail_addr}, {71'b0, s_addr});
            chk(fail_exp == s_exp, "R5", fail_exp, s_exp);
            chk(fail_got == s_got, "R5", fail_got, s_got);
        end
        @(negedge clk);
        chk(!done && !wr_valid && !rd_ready, "R8", {126'b0, done, wr_valid}, 128'b0);
        chk(verify_fail == bad_seen, "R7", {127'b0, verify_fail}, {127'b0, bad_seen});
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && byte_count == 0 && !verify_fail && !wr_valid && !rd_ready,
            "R9", {71'b0, byte_count}, 128'b0);
        // R1 R2 R3 R4: every pattern code on write, with stalls
        for (int p = 0; p < 8; p++)
            run_xfer(1'b0, p, {16'b0, $urandom}, 48'd1, -1, -1, 30);
        // R4: zero seed case; R2: address at the top of the sector range
        run_xfer(1'b0, 4, 48'd0, 48'd1, -1, -1, 0);
        run_xfer(1'b0, 0, 48'hFFFF_FFFF_FFFF, 48'd2, -1, -1, 50);
        // R8: zero length
        run_xfer(1'b0, 0, 48'd5, 48'd0, -1, -1, 0);
        run_xfer(1'b1, 4, 48'd9, 48'd0, -1, -1, 0);
        // R5 R7: clean read, then read with two corrupted beats
        run_xfer(1'b1, 4, 48'h1234_5678, 48'd1, -1, -1, 25);
        run_xfer(1'b1, 0, 48'd77, 48'd2, 5, 40, 25);
        // R9: new start clears the failure of the previous run
        run_xfer(1'b1, 1, 48'd3, 48'd1, -1, -1, 10);
        // random mix
        for (int n = 0; n < 6; n++) begin
            int b1;
            b1 = $urandom_range(31);
            run_xfer(1'($urandom_range(1)), int'($urandom_range(7)),
                     {16'b0, $urandom}, 48'($urandom_range(3) + 1),
                     b1, b1 + 3, 40);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule